// File: doc/BRIEF.md
# Three-Channel PWM Dead-Time Inserter

This block sits between the compare logic of a PWM timer and the gate drivers of three half-bridges. For each channel it takes a one-bit compare state. It drives a complementary pair of outputs: a high side, which is active while the compare state is 1, and a low side, which is active while the compare state is 0. When dead-time insertion is on for a channel, every edge on which one side of the pair turns on is held back by a programmable number of timer ticks. The side that turns off does so at once. As a result, the two switches of a bridge leg are never on together, and there is a guard gap between them.

Each channel has its own down-counter, which is loaded from a single shared 8-bit dead-time value. The counters decrement only on cycles where the timer's tick-enable is high. This makes the inserted gap equal in timer units for edge-aligned and center-aligned PWM, so a 50% duty input gives each side an on-time of half the period minus the dead time. A counter is loaded only while it is zero. A separate synchronous clear input zeroes all counters, and this clear is independent of any timer reset. A per-channel run flag shows which counters are still nonzero. All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: Each of the three channels has its own enable bit (`dt_en[i]`) and its own counter. Activity on one channel never changes the outputs or run flag of another channel.
- R2: A channel is armed when `dt_en[i]` is 1 and `dt_value` is nonzero. On a clock edge where an armed channel sees `cmp_state[i]` differ from its registered compare state and its counter is zero, the counter loads `dt_value`. Both outputs of that channel then stay at 0 until the counter returns to zero. Only after that does the side selected by the new state (high side for 1, low side for 0) go to 1.
- R3: A compare change that arrives while the channel's counter is nonzero does not reload the counter. The counter keeps running down from its current value.
- R4: A nonzero counter decrements by one only at edges where `tick_en` is 1. It holds its value at edges where `tick_en` is 0. With `tick_en` held at 1, the gap after a change lasts exactly `dt_value` cycles.
- R5: An edge with `dt_clr` high zeroes every counter. From the next cycle no delay is pending, and the outputs follow the registered compare state.
- R6: `dt_run[i]` is 1 exactly while channel i's counter is nonzero.
- R7: A channel that is not armed (`dt_en[i]` is 0 or `dt_value` is 0) forces its counter to zero at the next edge. Its outputs follow the compare state one cycle after it is sampled, with no extra delay, and `dt_run[i]` stays 0.
- R8: `hs_out[i]` and `ls_out[i]` are never 1 in the same cycle. The side that is turning off goes to 0 in the first cycle after the compare change.
- R9: While `rst_n` is low, all registered compare states and counters are zero. This gives `hs_out` = 0, `ls_out` = all ones and `dt_run` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick-enable; counters decrement only on these cycles |
| dt_clr | input | 1 | Synchronous clear of all dead-time counters |
| dt_en | input | NUM_CH | Per-channel dead-time enable |
| dt_value | input | DT_W | Shared dead-time length in ticks |
| cmp_state | input | NUM_CH | Compare state per channel (1 = high side active) |
| hs_out | output | NUM_CH | High-side output per channel, 1 = active |
| ls_out | output | NUM_CH | Low-side output per channel, 1 = active |
| dt_run | output | NUM_CH | Per-channel counter-nonzero flag |

## Verification
The hardest situation to reach from the ports is a compare change that lands while its channel's counter is still nonzero, so that a reload request must be dropped. If compare toggles are random and the dead time is long, this almost never happens together with the counter stalled by a low tick-enable. The directed part of the bench toggles a channel twice within a short dead time, both with tick-enable held and with it gapped. The random part uses short dead-time values and a high toggle rate, so that requests landing on a busy counter happen often. It also fires `dt_clr` and enable changes in the middle of a count.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int unsigned NUM_CH_DEF = 3;
  localparam int unsigned DT_W_DEF   = 8;

  // Complementary output pair of one bridge leg.
  typedef struct packed {
    logic hs;
    logic ls;
  } leg_t;

  // Output pair for a registered compare state, gated by a pending delay.
  function automatic leg_t leg_drive(input logic state, input logic hold);
    leg_t r;
    r.hs = state  & ~hold;
    r.ls = ~state & ~hold;
    return r;
  endfunction
endpackage

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic            armed,
  input  logic            load_req,
  input  logic [DT_W-1:0] load_val,
  output logic            busy
);
  logic [DT_W-1:0] cnt_q;
  logic            is_zero;

  assign is_zero = (cnt_q == '0);
  assign busy    = ~is_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !armed) begin
      cnt_q <= '0;
    end else if (load_req && is_zero) begin
      cnt_q <= load_val;
    end else if (tick && !is_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: clear empties the counter
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R3: a busy counter is never reloaded, it only holds or steps down
  p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_zero && !clr && armed) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));

  // R4: without a tick a busy counter holds
  p_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_zero && !clr && armed && !tick) |=> $stable(cnt_q));

  // R7: a channel that is not armed ends up idle
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> is_zero);
endmodule

// File: rtl/pdt_channel.sv
module pdt_channel
  import pdt_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clr,
  input  logic            en,
  input  logic [DT_W-1:0] dt_val,
  input  logic            cmp_in,
  output leg_t            leg,
  output logic            running
);
  logic state_q;
  logic change;
  logic armed;
  logic busy;

  assign armed  = en && (dt_val != '0);
  assign change = (cmp_in != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= cmp_in;
  end

  pdt_counter #(.DT_W(DT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .tick     (tick),
    .armed    (armed),
    .load_req (change),
    .load_val (dt_val),
    .busy     (busy)
  );

  assign leg     = leg_drive(state_q, busy);
  assign running = busy;

  // R8: the side being released is off right after the change
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (change && !cmp_in) |=> !leg.hs);
  // R2: an armed change from idle always opens a gap
  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (change && armed && !busy && !clr) |=> (!leg.hs && !leg.ls));
endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
  import pdt_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned DT_W   = DT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              dt_clr,
  input  logic [NUM_CH-1:0] dt_en,
  input  logic [DT_W-1:0]   dt_value,
  input  logic [NUM_CH-1:0] cmp_state,
  output logic [NUM_CH-1:0] hs_out,
  output logic [NUM_CH-1:0] ls_out,
  output logic [NUM_CH-1:0] dt_run
);
  leg_t legs [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pdt_channel #(.DT_W(DT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en),
      .clr     (dt_clr),
      .en      (dt_en[i]),
      .dt_val  (dt_value),
      .cmp_in  (cmp_state[i]),
      .leg     (legs[i]),
      .running (dt_run[i])
    );
    assign hs_out[i] = legs[i].hs;
    assign ls_out[i] = legs[i].ls;
  end

  // R8: never both sides of a leg on together
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out & ls_out) == '0);
  // R6: a running channel drives neither side
  p_run_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_run & (hs_out | ls_out)) == '0);
endmodule

// File: tb/pwm_deadtime_gen_bench.sv
module pwm_deadtime_gen_bench;
  localparam int NCH = 3;
  localparam int DW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick_en = 1'b1;
  logic           dt_clr = 1'b0;
  logic [NCH-1:0] dt_en = '0;
  logic [DW-1:0]  dt_value = '0;
  logic [NCH-1:0] cmp_state = '0;
  logic [NCH-1:0] hs_out, ls_out, dt_run;

  int n_vec = 0;
  int n_bad = 0;
  int m_state [NCH];
  int m_cnt   [NCH];

  always #2 clk = ~clk;

  pwm_deadtime_gen #(.NUM_CH(NCH), .DT_W(DW)) u_pwm_deadtime_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dt_clr(dt_clr),
    .dt_en(dt_en), .dt_value(dt_value), .cmp_state(cmp_state),
    .hs_out(hs_out), .ls_out(ls_out), .dt_run(dt_run)
  );

  function automatic int next_cnt(int cnt, bit chg, bit armed, bit clr, bit tk, int dv);
    if (clr || !armed) return 0;
    if (chg && cnt == 0) return dv;
    if (tk && cnt != 0) return cnt - 1;
    return cnt;
  endfunction

  function automatic logic [3*NCH-1:0] expect_out();
    logic [NCH-1:0] h, l, r;
    for (int i = 0; i < NCH; i++) begin
      r[i] = (m_cnt[i] != 0);
      h[i] = (m_state[i] != 0) && !r[i];
      l[i] = (m_state[i] == 0) && !r[i];
    end
    return {h, l, r};
  endfunction

  task automatic check(string tag);
    logic [3*NCH-1:0] exp_v, act_v;
    exp_v = expect_out();
    act_v = {hs_out, ls_out, dt_run};
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: {hs,ls,run} actual %b expected %b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // Apply the driven inputs at the next edge, update the model, check at negedge.
  task automatic step(string tag);
    bit chg [NCH];
    for (int i = 0; i < NCH; i++) chg[i] = (int'(cmp_state[i]) != m_state[i]);
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      m_cnt[i] = next_cnt(m_cnt[i], chg[i], dt_en[i] && dt_value != 0,
                          dt_clr, tick_en, int'(dt_value));
      m_state[i] = int'(cmp_state[i]);
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) begin m_state[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    check("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9");

    // R2/R4: gap of exactly dt_value cycles on channel 0
    dt_en = 3'b001; dt_value = 8'd4;
    step("R2");
    cmp_state[0] = 1'b1;
    step("R8");
    cmp_state[0] = 1'b1;
    repeat (5) step("R2");
    // R1: channel 1 without enable follows immediately during channel 0 gap
    cmp_state = 3'b010;
    step("R1");
    repeat (4) step("R4");

    // R3: second toggle while busy is ignored, with gapped ticks
    dt_value = 8'd6;
    cmp_state[0] = 1'b1;
    step("R3");
    cmp_state[0] = 1'b0;
    step("R3");
    tick_en = 1'b0;
    repeat (2) step("R4");
    cmp_state[0] = 1'b1;
    step("R3");
    tick_en = 1'b1;
    repeat (8) step("R3");

    // R5: clear in the middle of a count
    cmp_state[0] = 1'b0;
    step("R5");
    dt_clr = 1'b1;
    step("R5");
    dt_clr = 1'b0;
    step("R5");

    // R7: zero value and disabled channel bypass
    dt_en = 3'b111; dt_value = 8'd0;
    cmp_state = 3'b101;
    step("R7");
    dt_value = 8'd3; dt_en = 3'b000;
    cmp_state = 3'b010;
    step("R7");
    dt_en = 3'b111;
    cmp_state = 3'b111;
    step("R6");
    dt_en = 3'b101;
    step("R7");
    repeat (4) step("R6");

    // random mix, short dead times to hit busy reloads often
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 3) == 0) cmp_state = cmp_state ^ NCH'($urandom_range(1, 7));
      tick_en  = ($urandom_range(0, 3) != 0);
      dt_clr   = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 99) == 0) dt_en = NCH'($urandom_range(0, 7));
      if ($urandom_range(0, 199) == 0) dt_value = DW'($urandom_range(0, 9));
      if ($urandom_range(0, 499) == 0) dt_en = '1;
      step("R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule